// File: doc/BRIEF.md
# Saturating Rounding Narrowing Shifter

This block takes a 128-bit vector of signed wide elements and narrows each one to an unsigned element of half the width. Every element is shifted right arithmetically by an amount taken from a 7-bit immediate. The shift is rounded to the nearest value, and the result is clamped into the unsigned range of the narrow width. The narrow results are packed into a 64-bit result. That result is then placed in either the low or the high half of a 128-bit destination, or, in scalar mode, only the lowest element is processed and kept.

The same immediate sets both the element size and the shift amount. Its top bits give the narrow element size. Subtracting the whole immediate from twice that size gives the shift. Encodings that have no meaning raise an undefined flag and leave the destination untouched. Any clamping sets a sticky saturation flag, which stays set until a synchronous clear. The destination, the undefined flag and the saturation flag are registered, so results appear one clock after a valid strobe.

Top module: `sat_narrow_shifter`

## Requirements
- R1: The narrow size follows the highest set bit among imm_i[5:3]: imm_i[5]=1 gives 32 bits, else imm_i[4]=1 gives 16 bits, else imm_i[3]=1 gives 8 bits. Each source element is twice the narrow size.
- R2: The shift amount is 2×size minus the unsigned value of imm_i[6:0], which ranges from 1 to size. The element is rounded by adding 2^(shift−1) before the arithmetic right shift, with enough precision that the most positive source cannot wrap.
- R3: When imm_i[6]=1 or imm_i[6:3]=0000, a strobe sets undef_o to 1 on the next cycle and leaves dst_o and sat_o as a non-strobe cycle would. A strobe with a legal immediate clears undef_o.
- R4: A rounded result below zero becomes 0. A rounded result above 2^size−1 becomes all ones. Both cases count as saturation, and a negative source always yields 0.
- R5: In vector mode (scalar_i=0), there are 64/size lanes. Lane e reads signed bits [e·2·size +: 2·size] of src_i and writes bits [e·size +: size] of the 64-bit result.
- R6: In vector mode with upper_i=0, the result goes to dst_o[63:0] and dst_o[127:64] is cleared.
- R7: In vector mode with upper_i=1, the result goes to dst_o[127:64] and dst_o[63:0] takes dst_old_i[63:0].
- R8: In scalar mode (scalar_i=1), only element 0 is processed. It goes to dst_o[size-1:0], and every bit above it is cleared. upper_i has no effect. Other lanes neither write nor saturate.
- R9: sat_o sets when a legal strobe saturates any processed lane, and it holds until sat_clr_i. If a clear and a saturation happen in the same cycle, the saturation wins.
- R10: dst_o and undef_o change only in the cycle after a strobe on valid_i. Without a strobe, they hold.
- R11: After reset, dst_o, sat_o and undef_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| imm_i | input | 7 | Size and shift immediate |
| scalar_i | input | 1 | 1 = single element, 0 = vector |
| upper_i | input | 1 | Vector mode: write the upper half and keep the lower |
| src_i | input | 128 | Wide signed source elements |
| dst_old_i | input | 128 | Previous destination value |
| sat_clr_i | input | 1 | Synchronous clear of the sticky flag |
| dst_o | output | 128 | Registered destination |
| sat_o | output | 1 | Sticky saturation flag |
| undef_o | output | 1 | Last strobe used an undefined immediate |

## Verification
A wrong size decode or a wrong shift count shows up in dst_o one cycle after the strobe, as lanes landing at the wrong offsets or values off by a power of two. Loss of rounding precision shows up in the same cycle as a wrap, where a large positive source reads as 0 instead of all ones. A merge fault shows as a corrupted half that should have been kept or cleared. A fault in the sticky flag may stay hidden until a later strobe that does not saturate, and that is why sat_o is compared after every operation.

// File: rtl/snarrow_pkg.sv
`timescale 1ns/1ps
package snarrow_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2
  } esz_e;

  localparam int unsigned NUM_SIZES = 3;

  // Narrow element width in bits for a size code.
  function automatic logic [6:0] esz_bits(input esz_e e);
    case (e)
      ESZ_16:  return 7'd16;
      ESZ_32:  return 7'd32;
      default: return 7'd8;
    endcase
  endfunction

endpackage

// File: rtl/snarrow_decode.sv
`timescale 1ns/1ps
module snarrow_decode
  import snarrow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] imm_i,
  output esz_e       esz_o,
  output logic [5:0] shamt_o,
  output logic       illegal_o
);

  logic [3:0] hi_field;
  logic [6:0] twice_w;

  assign hi_field  = imm_i[6:3];
  assign illegal_o = hi_field[3] | (hi_field == 4'd0);

  always_comb begin
    if (hi_field[2])      esz_o = ESZ_32;
    else if (hi_field[1]) esz_o = ESZ_16;
    else                  esz_o = ESZ_8;
  end

  assign twice_w = esz_bits(esz_o) << 1;
  assign shamt_o = 6'(twice_w - imm_i);

  // R2: a legal immediate always yields a shift of 1..size
  a_r2_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_o |-> (shamt_o >= 6'd1) && ({1'b0, shamt_o} <= esz_bits(esz_o)));

endmodule

// File: rtl/snarrow_lanes.sv
`timescale 1ns/1ps
module snarrow_lanes #(
  parameter int unsigned HALF_W = 64,
  parameter int unsigned NW     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] src_i,
  input  logic [5:0]          shamt_i,
  input  logic                scalar_i,
  output logic [HALF_W-1:0]   res_o,
  output logic                sat_o
);

  localparam int unsigned NL = HALF_W / NW;
  localparam int unsigned SW = 2 * NW;
  localparam int unsigned EW = SW + 2;
  localparam logic signed [EW-1:0] MAXV = {{(EW-NW){1'b0}}, {NW{1'b1}}};

  // Returns {saturated, narrow value}.
  function automatic logic [NW:0] round_sat(input logic [SW-1:0] s,
                                            input logic [5:0]    sh);
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] one;
    logic signed [EW-1:0] bias;
    logic signed [EW-1:0] q;
    ext  = EW'(signed'(s));
    one  = 1;
    bias = one <<< (sh - 6'd1);
    q    = (ext + bias) >>> sh;
    if (q < 0)          return {1'b1, {NW{1'b0}}};
    else if (q > MAXV)  return {1'b1, {NW{1'b1}}};
    else                return {1'b0, q[NW-1:0]};
  endfunction

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [NW:0] r;
    logic        keep;
    assign keep = (i == 0) || !scalar_i;
    assign r    = round_sat(src_i[i*SW +: SW], shamt_i);
    assign res_o[i*NW +: NW] = keep ? r[NW-1:0] : '0;
    assign lane_sat[i]       = keep & r[NW];

    // R4: a negative source never produces a non-zero narrow value
    a_r4_neg_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (keep && src_i[i*SW+SW-1]) |-> (res_o[i*NW +: NW] == '0));
  end

  assign sat_o = |lane_sat;

endmodule

// File: rtl/snarrow_merge.sv
`timescale 1ns/1ps
module snarrow_merge #(
  parameter int unsigned DST_W = 128
) (
  input  logic [DST_W/2-1:0] res_i,
  input  logic               scalar_i,
  input  logic               upper_i,
  input  logic [DST_W-1:0]   old_i,
  output logic [DST_W-1:0]   new_o
);

  localparam int unsigned HALF_W = DST_W / 2;

  always_comb begin
    if (!scalar_i && upper_i) new_o = {res_i, old_i[HALF_W-1:0]};
    else                      new_o = {{HALF_W{1'b0}}, res_i};
  end

endmodule

// File: rtl/sat_narrow_shifter.sv
`timescale 1ns/1ps
module sat_narrow_shifter
  import snarrow_pkg::*;
#(
  parameter int unsigned DST_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [6:0]       imm_i,
  input  logic             scalar_i,
  input  logic             upper_i,
  input  logic [DST_W-1:0] src_i,
  input  logic [DST_W-1:0] dst_old_i,
  input  logic             sat_clr_i,
  output logic [DST_W-1:0] dst_o,
  output logic             sat_o,
  output logic             undef_o
);

  localparam int unsigned HALF_W = DST_W / 2;

  esz_e             esz;
  logic [5:0]       shamt;
  logic             illegal;
  logic [HALF_W-1:0] grp_res [NUM_SIZES];
  logic              grp_sat [NUM_SIZES];
  logic [HALF_W-1:0] narrow;
  logic              sat_any;
  logic [DST_W-1:0]  merged;
  logic              wr_ok;
  logic              sat_evt;
  logic [DST_W-1:0]  dst_q;
  logic              sat_q;
  logic              undef_q;

  snarrow_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .imm_i    (imm_i),
    .esz_o    (esz),
    .shamt_o  (shamt),
    .illegal_o(illegal)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    snarrow_lanes #(.HALF_W(HALF_W), .NW(8 << g)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i),
      .shamt_i (shamt),
      .scalar_i(scalar_i),
      .res_o   (grp_res[g]),
      .sat_o   (grp_sat[g])
    );
  end

  always_comb begin
    case (esz)
      ESZ_16:  begin narrow = grp_res[1]; sat_any = grp_sat[1]; end
      ESZ_32:  begin narrow = grp_res[2]; sat_any = grp_sat[2]; end
      default: begin narrow = grp_res[0]; sat_any = grp_sat[0]; end
    endcase
  end

  snarrow_merge #(.DST_W(DST_W)) u_merge (
    .res_i   (narrow),
    .scalar_i(scalar_i),
    .upper_i (upper_i),
    .old_i   (dst_old_i),
    .new_o   (merged)
  );

  assign wr_ok   = valid_i & ~illegal;
  assign sat_evt = wr_ok & sat_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q   <= '0;
      sat_q   <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      if (valid_i) undef_q <= illegal;
      if (wr_ok)   dst_q   <= merged;
      sat_q <= (sat_q & ~sat_clr_i) | sat_evt;
    end
  end

  assign dst_o   = dst_q;
  assign sat_o   = sat_q;
  assign undef_o = undef_q;

  // R3: an undefined immediate leaves the destination alone and flags it
  a_r3_undef_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && illegal) |=> ($stable(dst_o) && undef_o));

  // R6: lower-half write clears the upper half
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !scalar_i && !upper_i) |=> (dst_o[DST_W-1:HALF_W] == '0));

  // R7: upper-half write keeps the old lower half
  a_r7_lower_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !scalar_i && upper_i) |=>
      (dst_o[HALF_W-1:0] == $past(dst_old_i[HALF_W-1:0])));

  // R8: scalar writes nothing above the widest narrow element
  a_r8_scalar_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && scalar_i) |=> (dst_o[DST_W-1:32] == '0));

  // R9: sticky flag holds without a clear, and a saturation always sets it
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_o && !sat_clr_i) |=> sat_o);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> sat_o);

  // R10: no strobe, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(dst_o) && $stable(undef_o)));

endmodule

// File: tb/sat_narrow_shifter_tb.sv
`timescale 1ns/1ps
module sat_narrow_shifter_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [6:0]   imm_i = '0;
  logic         scalar_i = 1'b0;
  logic         upper_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [127:0] dst_old_i = '0;
  logic         sat_clr_i = 1'b0;
  logic [127:0] dst_o;
  logic         sat_o;
  logic         undef_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [127:0] m_dst = '0;
  logic         m_sat = 1'b0;
  logic         m_undef = 1'b0;

  always #4 clk = ~clk;

  sat_narrow_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .imm_i(imm_i),
    .scalar_i(scalar_i), .upper_i(upper_i), .src_i(src_i),
    .dst_old_i(dst_old_i), .sat_clr_i(sat_clr_i),
    .dst_o(dst_o), .sat_o(sat_o), .undef_o(undef_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [127:0] sx(input logic [127:0] v, input int w);
    logic [127:0] t;
    t = v & ((128'd1 << w) - 128'd1);
    if (t[w-1]) return signed'(t - (128'd1 << w));
    return signed'(t);
  endfunction

  // Rounded division by 2^s done with integer floor division, then clamp.
  function automatic logic [32:0] ref_lane(input logic signed [127:0] x, input int s, input int nw);
    logic signed [127:0] den, num, q, maxv;
    den  = 128'sd1 <<< s;
    num  = x + (den >>> 1);
    if (num >= 0) q = num / den;
    else          q = -((-num + den - 128'sd1) / den);
    maxv = (128'sd1 <<< nw) - 128'sd1;
    if (q < 0)         return {1'b1, 32'd0};
    else if (q > maxv) return {1'b1, maxv[31:0]};
    else               return {1'b0, q[31:0]};
  endfunction

  task automatic apply(input string tag, input logic [6:0] imm, input logic sc,
                       input logic up, input logic [127:0] src,
                       input logic [127:0] old, input logic clr);
    logic [3:0]   hf;
    logic         bad;
    int           nw, s, nl;
    logic [127:0] res;
    logic         any;
    logic [32:0]  lv;
    imm_i = imm; scalar_i = sc; upper_i = up; src_i = src;
    dst_old_i = old; sat_clr_i = clr; valid_i = 1'b1;
    hf  = imm[6:3];
    bad = hf[3] || (hf == 4'd0);
    any = 1'b0;
    if (!bad) begin
      nw  = hf[2] ? 32 : (hf[1] ? 16 : 8);
      s   = 2 * nw - int'(imm);
      nl  = sc ? 1 : 64 / nw;
      res = '0;
      for (int e = 0; e < nl; e++) begin
        lv  = ref_lane(sx(src >> (e * 2 * nw), 2 * nw), s, nw);
        any = any | lv[32];
        res = res | ({96'd0, lv[31:0]} << (e * nw));
      end
      if (!sc && up) m_dst = {res[63:0], old[63:0]};
      else           m_dst = res;
    end
    m_undef = bad;
    m_sat   = (m_sat & ~clr) | any;
    @(negedge clk);
    valid_i = 1'b0; sat_clr_i = 1'b0;
    chk(tag, dst_o, m_dst);
    chk("R9 sat_o", {127'd0, sat_o}, {127'd0, m_sat});
    chk("R3 undef_o", {127'd0, undef_o}, {127'd0, m_undef});
  endtask

  function automatic logic [127:0] pick(input int nw, input int s);
    logic signed [127:0] v;
    int d;
    d = int'($urandom % 5) - 2;
    case ($urandom % 5)
      0: v = signed'({64'd0, $urandom, $urandom});
      1: v = (128'sd1 <<< (nw + s)) - (128'sd1 <<< (s - 1)) + d;
      2: v = -(128'sd1 <<< (s - 1)) + d;
      3: v = (128'sd1 <<< (2 * nw - 1)) - 128'sd1;
      default: v = -(128'sd1 <<< (2 * nw - 1));
    endcase
    return v & ((128'd1 << (2 * nw)) - 128'd1);
  endfunction

  task automatic rand_run(input int nw, input int count);
    logic [6:0]   imm;
    logic [127:0] src;
    logic         sc, up;
    int           s;
    string        tag;
    for (int k = 0; k < count; k++) begin
      imm = 7'(2 * nw - 1 - int'($urandom % nw));
      s   = 2 * nw - int'(imm);
      src = '0;
      for (int e = 0; e < 128 / (2 * nw); e++)
        src = src | (pick(nw, s) << (e * 2 * nw));
      sc  = ($urandom % 6) == 0;
      up  = $urandom % 2;
      tag = sc ? "R8 scalar" : (up ? "R7 upper" : "R6 lower");
      apply(tag, imm, sc, up, src, {$urandom, $urandom, $urandom, $urandom},
            ($urandom % 8) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 dst", dst_o, '0);
    chk("R11 flags", {126'd0, sat_o, undef_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: 8-bit size, every 16-bit source value, shifts 8..1
    for (int k = 0; k < 8192; k++) begin
      logic [127:0] src;
      src = '0;
      for (int j = 0; j < 8; j++)
        src[j*16 +: 16] = 16'(8 * k + j);
      apply("R5 b-sweep", 7'(8 + k % 8), 1'b0, k[3],
            src, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    end

    // R2: largest positive source at shift 1 must not wrap
    apply("R2 no-wrap", 7'd63, 1'b0, 1'b0,
          {2{64'h7FFF_FFFF_FFFF_FFFF}}, '0, 1'b1);
    chk("R2 all-ones", dst_o, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});
    // R4: rounding of -2^(s-1) reaches 0 without saturating
    apply("R4 round-zero", 7'd32, 1'b0, 1'b0,
          {64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000}, '0, 1'b1);
    chk("R4 no-sat", {127'd0, sat_o}, '0);

    rand_run(8, 300);
    rand_run(16, 1500);
    rand_run(32, 1500);

    // R8: scalar ignores upper_i; saturating lane 1 must not flag
    apply("R8 scalar-up", 7'd15, 1'b1, 1'b1,
          {112'h7FFF, 16'h0004}, '1, 1'b1);
    chk("R8 value", dst_o, 128'd2);
    chk("R8 lane1 no sat", {127'd0, sat_o}, '0);

    // R3: undefined encodings
    for (int k = 0; k < 8; k++)
      apply("R3 zero-hi", 7'(k), 1'b0, 1'b0, '1, '1, 1'b0);
    for (int k = 0; k < 16; k++)
      apply("R3 hi-bit", 7'(64 + k * 4), 1'b0, 1'b1, '1, '1, 1'b0);

    // R9: saturation with simultaneous clear keeps flag set, then clear alone
    apply("R9 set", 7'd15, 1'b0, 1'b0, {8{16'h7FFF}}, '0, 1'b1);
    chk("R9 set-wins", {127'd0, sat_o}, 128'd1);
    apply("R9 keep", 7'd8, 1'b0, 1'b0, '0, '0, 1'b0);
    sat_clr_i = 1'b1;
    @(negedge clk);
    sat_clr_i = 1'b0;
    m_sat = 1'b0;
    chk("R9 cleared", {127'd0, sat_o}, '0);

    // R10: inputs move without a strobe, outputs hold
    src_i = '1; imm_i = 7'd9; dst_old_i = '1; upper_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 hold dst", dst_o, m_dst);
    chk("R10 hold undef", {127'd0, undef_o}, {127'd0, m_undef});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule